// File: doc/BRIEF.md
# Keypad Controller Command Processor

This block sits behind a byte-oriented serial slave link of a keypad-controller peripheral and turns the byte stream into register updates. The link layer reports three things: the start of a transfer, a byte written by the host, and a request to supply one byte to the host. After a start, the first byte written is a command code. Later written bytes are parameters, numbered from 0. Bytes read after a start are numbered from 0 and answer the command latched earlier.

The processor holds the settings used by the rest of the peripheral: configuration, active time, debounce, keypad size and clock. It also holds three 16-bit GPIO words (pull select, direction and state), the interrupt status byte and the sticky error byte. Each command checks its own arguments. Once a command has taken its last byte, the latched code becomes the reserved value 0xFF, so any surplus parameter byte is reported as an error. Commands for the PWM engine are only checked here. Accepted ones leave as single-cycle strobes for that engine.

Both byte streams use valid/ready. A written byte is taken on a cycle with `wr_valid_i && wr_ready_o`. `wr_ready_o` drops only while `start_i` is high. A read request is taken on a cycle with `rd_valid_i && rd_ready_o`. `rd_ready_o` drops while `start_i` or `wr_valid_i` is high. The answer appears on the next cycle with `rd_data_valid_o` high for one cycle; it has no ready and must be taken.

Top module: `kpc_cmd_proc`

## Requirements
- R1: After reset: `cfg_o`=0x80, `act_time_o`=125, `debounce_o`=3, `key_size_o`=0x33, `clk_cfg_o`=0x08, all GPIO words are 0, the status byte is 0x10 (bit 4 = not initialised), the error byte is 0 and `irq_n_o` is low.
- R2: A start clears the byte index. The first byte written after a start is latched as the command, and each later written byte is parameter (index-1). Settings change only on an accepted written byte.
- R3: Once a command has taken its final byte, the latched code is 0xFF. A further written byte then sets error bit 0 (bad parameter) and leaves every setting unchanged.
- R4: A parameter byte written under a code with no write action, or a read under a code that is neither a known read, a write-only command nor 0xFF, sets error bit 1 (unknown command). Setting any error bit also sets status bit 3. The error byte is sticky and reads back under 0x8C.
- R5: Command 0x83 with parameter 0xAA restores the R1 values of configuration, status, active time, debounce, keypad size and clock. Any other parameter value is a bad parameter and changes none of them.
- R6: Reading byte 0 of 0x82 returns the status byte and clears it, unless status bit 4 is set. Writing config (0x81, one byte) stores the byte, clears status and gives a one-cycle `key_flush_o` pulse.
- R7: 0x8F (debounce), 0x90 (keypad size) and 0x93 (clock) store their byte. The value is a bad parameter when the debounce is 0, when the size's low nibble is outside 3..12 or its high nibble is outside 3..8, or when the clock's low two bits are 01 or 10. 0x91 reads the size back. 0x94 reads the clock back with its low two bits forced to 10.
- R8: 0x80 reads 0x00 then 0x04 (the value 0x0400, low byte first). 0x92 reads the low nibble of config with the high nibble zero. 0x8B stores the active time.
- R9: 0x84 (pull), 0x85 (direction) and 0x86 (state) load parameter 0 into the low byte and clear the high byte. Parameter 1 ORs into the high byte and completes the command. 0x87 reads direction and 0x88 reads state, low byte first.
- R10: 0x95 parameter 0 is a PWM address, and 0x96 takes a start value; in both, bits 1:0 are a channel 1..3 and bits 7:2 a step 0..59. Either is a bad parameter when bits 1:0 are 00 or bits 7:2 exceed 59. After a valid address, parameters 1 and 2 form a 16-bit word, high byte first, given out with `pwm_wr_valid_o`. A valid 0x96 gives `pwm_start_valid_o`. 0x97 gives `pwm_stop_valid_o` for channel bits 1:0, and 00 there is a bad parameter.
- R11: `irq_n_o` is low exactly when the status byte is nonzero.
- R12: Reads under write-only commands or 0xFF, and read indexes past a value's width, return 0x00 without setting any error.
- R13: `wr_ready_o` is low while `start_i` is high. `rd_ready_o` is low while `start_i` or `wr_valid_i` is high. Each accepted read gives exactly one `rd_data_valid_o` pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Transfer start in either direction |
| wr_valid_i | input | 1 | Written byte valid |
| wr_ready_o | output | 1 | Written byte can be taken |
| wr_data_i | input | 8 | Written byte |
| rd_valid_i | input | 1 | Read byte request |
| rd_ready_o | output | 1 | Read request can be taken |
| rd_data_valid_o | output | 1 | Read answer valid |
| rd_data_o | output | 8 | Read answer |
| irq_n_o | output | 1 | Interrupt, active low |
| cfg_o | output | 8 | Configuration byte |
| act_time_o | output | 8 | Active time |
| debounce_o | output | 8 | Debounce time |
| key_size_o | output | 8 | Keypad size, rows high nibble |
| clk_cfg_o | output | 8 | Clock setting |
| gpio_pull_o | output | 16 | GPIO pull select |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_state_o | output | 16 | GPIO state |
| key_flush_o | output | 1 | Empty the key FIFO, one cycle |
| pwm_wr_valid_o | output | 1 | PWM script word strobe |
| pwm_wr_addr_o | output | 8 | PWM script address byte |
| pwm_wr_data_o | output | 16 | PWM script word |
| pwm_start_valid_o | output | 1 | PWM start strobe |
| pwm_start_chan_o | output | 2 | PWM start channel |
| pwm_start_addr_o | output | 6 | PWM start step |
| pwm_stop_valid_o | output | 1 | PWM stop strobe |
| pwm_stop_chan_o | output | 2 | PWM stop channel |

## Verification
Status is hard to reach from the ports. Its bit 4 blocks the clear-on-read until config has been written. After that, an error shows only as status bit 3, and reading it clears it. Each directed scenario therefore provokes a single fault and reads 0x82 straight away. The error byte is checked as an accumulating value, because nothing ever clears it. The surplus-byte case needs a command finished and one more byte written in the same transfer. The stimulus covers this for a one-byte command and for a two-byte GPIO write.

// File: rtl/kpc_pkg.sv
package kpc_pkg;
  localparam logic [7:0] CMD_ID_RD    = 8'h80;
  localparam logic [7:0] CMD_CFG_WR   = 8'h81;
  localparam logic [7:0] CMD_STAT_RD  = 8'h82;
  localparam logic [7:0] CMD_RESET    = 8'h83;
  localparam logic [7:0] CMD_PULL_WR  = 8'h84;
  localparam logic [7:0] CMD_DIR_WR   = 8'h85;
  localparam logic [7:0] CMD_STATE_WR = 8'h86;
  localparam logic [7:0] CMD_DIR_RD   = 8'h87;
  localparam logic [7:0] CMD_STATE_RD = 8'h88;
  localparam logic [7:0] CMD_ACT_WR   = 8'h8B;
  localparam logic [7:0] CMD_ERR_RD   = 8'h8C;
  localparam logic [7:0] CMD_DEB_WR   = 8'h8F;
  localparam logic [7:0] CMD_SIZE_WR  = 8'h90;
  localparam logic [7:0] CMD_SIZE_RD  = 8'h91;
  localparam logic [7:0] CMD_CFG_RD   = 8'h92;
  localparam logic [7:0] CMD_CLK_WR   = 8'h93;
  localparam logic [7:0] CMD_CLK_RD   = 8'h94;
  localparam logic [7:0] CMD_PWM_WR   = 8'h95;
  localparam logic [7:0] CMD_PWM_GO   = 8'h96;
  localparam logic [7:0] CMD_PWM_HALT = 8'h97;
  localparam logic [7:0] CMD_PARK     = 8'hFF;

  localparam logic [7:0] RESET_KEY    = 8'hAA;
  localparam logic [15:0] ID_VALUE    = 16'h0400;

  localparam logic [7:0] RV_CFG   = 8'h80;
  localparam logic [7:0] RV_STAT  = 8'h10;
  localparam logic [7:0] RV_ACT   = 8'd125;
  localparam logic [7:0] RV_DEB   = 8'd3;
  localparam logic [7:0] RV_SIZE  = 8'h33;
  localparam logic [7:0] RV_CLK   = 8'h08;

  localparam int STAT_ERR_BIT    = 3;
  localparam int STAT_NOINIT_BIT = 4;
  localparam int ERR_BADARG_BIT  = 0;
  localparam int ERR_UNKCMD_BIT  = 1;

  localparam int NUM_GPIO_WORDS = 3;

  typedef struct packed {
    logic                      park;
    logic                      bad_arg;
    logic                      unk_cmd;
    logic                      do_reset;
    logic                      cfg_we;
    logic                      act_we;
    logic                      deb_we;
    logic                      size_we;
    logic                      clk_we;
    logic [NUM_GPIO_WORDS-1:0] gpio_lo_we;
    logic [NUM_GPIO_WORDS-1:0] gpio_hi_we;
    logic                      pwm_addr_we;
    logic                      pwm_hi_we;
    logic                      pwm_lo_we;
    logic                      pwm_go;
    logic                      pwm_halt;
  } wr_act_t;

  function automatic logic pwm_arg_bad(input logic [7:0] v, input int step_max);
    return (v[1:0] == 2'b00) || (int'(v[7:2]) > step_max);
  endfunction

  function automatic logic size_arg_bad(input logic [7:0] v, input int lo_min,
                                        input int lo_max, input int hi_max);
    return (int'(v[3:0]) < lo_min) || (int'(v[3:0]) > lo_max) ||
           (int'(v[7:4]) < lo_min) || (int'(v[7:4]) > hi_max);
  endfunction

  function automatic logic is_write_only(input logic [7:0] c);
    case (c)
      CMD_CFG_WR, CMD_RESET, CMD_PULL_WR, CMD_DIR_WR, CMD_STATE_WR,
      CMD_ACT_WR, CMD_DEB_WR, CMD_SIZE_WR, CMD_CLK_WR, CMD_PWM_WR,
      CMD_PWM_GO, CMD_PWM_HALT, CMD_PARK: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/kpc_cmd_seq.sv
module kpc_cmd_seq
  import kpc_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_fire_i,
  input  logic             rd_fire_i,
  input  logic [7:0]       wr_data_i,
  input  logic             park_i,
  output logic [7:0]       cmd_o,
  output logic [CYC_W-1:0] cyc_o
);
  localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

  logic [7:0]       cmd_q;
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_PARK;
      cyc_q <= '0;
    end else begin
      if (start_i) begin
        cyc_q <= '0;
      end else if ((wr_fire_i || rd_fire_i) && (cyc_q != CYC_MAX)) begin
        cyc_q <= cyc_q + 1'b1;
      end
      if (wr_fire_i) begin
        if (cyc_q == '0)  cmd_q <= wr_data_i;
        else if (park_i)  cmd_q <= CMD_PARK;
      end
    end
  end

  assign cmd_o = cmd_q;
  assign cyc_o = cyc_q;
endmodule

// File: rtl/kpc_wr_decode.sv
module kpc_wr_decode
  import kpc_pkg::*;
#(
  parameter int CYC_W        = 3,
  parameter int PWM_STEP_MAX = 59,
  parameter int KEY_DIM_MIN  = 3,
  parameter int KEY_LO_MAX   = 12,
  parameter int KEY_HI_MAX   = 8
) (
  input  logic             wr_fire_i,
  input  logic [7:0]       cmd_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic [7:0]       data_i,
  output wr_act_t          act_o
);
  logic [CYC_W-1:0] idx;

  always_comb begin
    idx   = cyc_i - 1'b1;
    act_o = '0;
    if (wr_fire_i && (cyc_i != '0)) begin
      case (cmd_i)
        CMD_CFG_WR: begin
          act_o.cfg_we = 1'b1;
          act_o.park   = 1'b1;
        end
        CMD_RESET: begin
          act_o.park = 1'b1;
          if (data_i == RESET_KEY) act_o.do_reset = 1'b1;
          else                     act_o.bad_arg  = 1'b1;
        end
        CMD_PULL_WR, CMD_DIR_WR, CMD_STATE_WR: begin
          if (idx == '0) begin
            act_o.gpio_lo_we = NUM_GPIO_WORDS'(1) << cmd_i[1:0];
          end else begin
            act_o.gpio_hi_we = NUM_GPIO_WORDS'(1) << cmd_i[1:0];
            act_o.park       = 1'b1;
          end
        end
        CMD_ACT_WR: begin
          act_o.act_we = 1'b1;
          act_o.park   = 1'b1;
        end
        CMD_DEB_WR: begin
          act_o.deb_we  = 1'b1;
          act_o.park    = 1'b1;
          act_o.bad_arg = (data_i == 8'h00);
        end
        CMD_SIZE_WR: begin
          act_o.size_we = 1'b1;
          act_o.park    = 1'b1;
          act_o.bad_arg = size_arg_bad(data_i, KEY_DIM_MIN, KEY_LO_MAX, KEY_HI_MAX);
        end
        CMD_CLK_WR: begin
          act_o.clk_we  = 1'b1;
          act_o.park    = 1'b1;
          act_o.bad_arg = data_i[1] ^ data_i[0];
        end
        CMD_PWM_WR: begin
          if (idx == '0) begin
            if (pwm_arg_bad(data_i, PWM_STEP_MAX)) begin
              act_o.bad_arg = 1'b1;
              act_o.park    = 1'b1;
            end else begin
              act_o.pwm_addr_we = 1'b1;
            end
          end else if (idx == CYC_W'(1)) begin
            act_o.pwm_hi_we = 1'b1;
          end else begin
            act_o.pwm_lo_we = 1'b1;
            act_o.park      = 1'b1;
          end
        end
        CMD_PWM_GO: begin
          act_o.park = 1'b1;
          if (pwm_arg_bad(data_i, PWM_STEP_MAX)) act_o.bad_arg = 1'b1;
          else                                   act_o.pwm_go  = 1'b1;
        end
        CMD_PWM_HALT: begin
          act_o.park = 1'b1;
          if (data_i[1:0] == 2'b00) act_o.bad_arg  = 1'b1;
          else                      act_o.pwm_halt = 1'b1;
        end
        CMD_PARK: act_o.bad_arg = 1'b1;
        default:  act_o.unk_cmd = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/kpc_rd_decode.sv
module kpc_rd_decode
  import kpc_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  logic             rd_fire_i,
  input  logic [7:0]       cmd_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic [7:0]       status_i,
  input  logic [7:0]       err_i,
  input  logic [7:0]       cfg_i,
  input  logic [7:0]       size_i,
  input  logic [7:0]       clk_cfg_i,
  input  logic [15:0]      dir_i,
  input  logic [15:0]      state_i,
  output logic [7:0]       data_o,
  output logic             clr_status_o,
  output logic             unk_cmd_o
);
  function automatic logic [7:0] pick(input logic [15:0] w, input logic [CYC_W-1:0] i);
    if (i == '0)              return w[7:0];
    else if (i == CYC_W'(1))  return w[15:8];
    else                      return 8'h00;
  endfunction

  always_comb begin
    data_o       = 8'h00;
    clr_status_o = 1'b0;
    unk_cmd_o    = 1'b0;
    if (rd_fire_i) begin
      case (cmd_i)
        CMD_ID_RD:    data_o = pick(ID_VALUE, cyc_i);
        CMD_STAT_RD:  begin
          if (cyc_i == '0) begin
            data_o       = status_i;
            clr_status_o = !status_i[STAT_NOINIT_BIT];
          end
        end
        CMD_DIR_RD:   data_o = pick(dir_i, cyc_i);
        CMD_STATE_RD: data_o = pick(state_i, cyc_i);
        CMD_ERR_RD:   data_o = pick({8'h00, err_i}, cyc_i);
        CMD_SIZE_RD:  data_o = pick({8'h00, size_i}, cyc_i);
        CMD_CFG_RD:   data_o = pick({12'h000, cfg_i[3:0]}, cyc_i);
        CMD_CLK_RD:   data_o = pick({8'h00, clk_cfg_i[7:2], 2'b10}, cyc_i);
        default:      unk_cmd_o = !is_write_only(cmd_i);
      endcase
    end
  end
endmodule

// File: rtl/kpc_reg_file.sv
module kpc_reg_file
  import kpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  wr_act_t     act_i,
  input  logic [7:0]  data_i,
  input  logic        rd_clr_i,
  input  logic        rd_unk_i,
  output logic [7:0]  status_o,
  output logic [7:0]  err_o,
  output logic [7:0]  cfg_o,
  output logic [7:0]  act_time_o,
  output logic [7:0]  debounce_o,
  output logic [7:0]  key_size_o,
  output logic [7:0]  clk_cfg_o,
  output logic [15:0] gpio_o [NUM_GPIO_WORDS],
  output logic        key_flush_o,
  output logic        pwm_wr_valid_o,
  output logic [7:0]  pwm_wr_addr_o,
  output logic [15:0] pwm_wr_data_o,
  output logic        pwm_go_valid_o,
  output logic [1:0]  pwm_go_chan_o,
  output logic [5:0]  pwm_go_step_o,
  output logic        pwm_halt_valid_o,
  output logic [1:0]  pwm_halt_chan_o
);
  logic [7:0] status_q, status_d, err_q;
  logic [7:0] cfg_q, act_q, deb_q, size_q, clk_q;
  logic       raise_bad, raise_unk;

  assign raise_bad = act_i.bad_arg;
  assign raise_unk = act_i.unk_cmd | rd_unk_i;

  always_comb begin
    status_d = status_q;
    if (act_i.cfg_we)   status_d = 8'h00;
    if (act_i.do_reset) status_d = RV_STAT;
    if (rd_clr_i)       status_d = 8'h00;
    if (raise_bad || raise_unk) status_d[STAT_ERR_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= RV_STAT;
      err_q    <= 8'h00;
      cfg_q    <= RV_CFG;
      act_q    <= RV_ACT;
      deb_q    <= RV_DEB;
      size_q   <= RV_SIZE;
      clk_q    <= RV_CLK;
    end else begin
      status_q <= status_d;
      if (raise_bad) err_q[ERR_BADARG_BIT] <= 1'b1;
      if (raise_unk) err_q[ERR_UNKCMD_BIT] <= 1'b1;
      if (act_i.do_reset) begin
        cfg_q  <= RV_CFG;
        act_q  <= RV_ACT;
        deb_q  <= RV_DEB;
        size_q <= RV_SIZE;
        clk_q  <= RV_CLK;
      end else begin
        if (act_i.cfg_we)  cfg_q  <= data_i;
        if (act_i.act_we)  act_q  <= data_i;
        if (act_i.deb_we)  deb_q  <= data_i;
        if (act_i.size_we) size_q <= data_i;
        if (act_i.clk_we)  clk_q  <= data_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_GPIO_WORDS; g++) begin : g_gpio
    logic [15:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                    word_q <= 16'h0000;
      else if (act_i.gpio_lo_we[g])  word_q <= {8'h00, data_i};
      else if (act_i.gpio_hi_we[g])  word_q <= word_q | {data_i, 8'h00};
    end
    assign gpio_o[g] = word_q;
  end

  logic        flush_q, pwm_wr_q, go_q, halt_q;
  logic [7:0]  pwm_addr_q;
  logic [15:0] pwm_word_q;
  logic [1:0]  go_chan_q, halt_chan_q;
  logic [5:0]  go_step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q     <= 1'b0;
      pwm_wr_q    <= 1'b0;
      go_q        <= 1'b0;
      halt_q      <= 1'b0;
      pwm_addr_q  <= 8'h00;
      pwm_word_q  <= 16'h0000;
      go_chan_q   <= 2'b00;
      go_step_q   <= 6'd0;
      halt_chan_q <= 2'b00;
    end else begin
      flush_q  <= act_i.cfg_we;
      pwm_wr_q <= act_i.pwm_lo_we;
      go_q     <= act_i.pwm_go;
      halt_q   <= act_i.pwm_halt;
      if (act_i.pwm_addr_we) begin
        pwm_addr_q <= data_i;
        pwm_word_q <= 16'h0000;
      end
      if (act_i.pwm_hi_we) pwm_word_q[15:8] <= data_i;
      if (act_i.pwm_lo_we) pwm_word_q[7:0]  <= data_i;
      if (act_i.pwm_go) begin
        go_chan_q <= data_i[1:0];
        go_step_q <= data_i[7:2];
      end
      if (act_i.pwm_halt) halt_chan_q <= data_i[1:0];
    end
  end

  assign status_o         = status_q;
  assign err_o            = err_q;
  assign cfg_o            = cfg_q;
  assign act_time_o       = act_q;
  assign debounce_o       = deb_q;
  assign key_size_o       = size_q;
  assign clk_cfg_o        = clk_q;
  assign key_flush_o      = flush_q;
  assign pwm_wr_valid_o   = pwm_wr_q;
  assign pwm_wr_addr_o    = pwm_addr_q;
  assign pwm_wr_data_o    = pwm_word_q;
  assign pwm_go_valid_o   = go_q;
  assign pwm_go_chan_o    = go_chan_q;
  assign pwm_go_step_o    = go_step_q;
  assign pwm_halt_valid_o = halt_q;
  assign pwm_halt_chan_o  = halt_chan_q;
endmodule

// File: rtl/kpc_cmd_proc.sv
module kpc_cmd_proc
  import kpc_pkg::*;
#(
  parameter int CYC_W        = 3,
  parameter int PWM_STEP_MAX = 59,
  parameter int KEY_DIM_MIN  = 3,
  parameter int KEY_LO_MAX   = 12,
  parameter int KEY_HI_MAX   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        wr_valid_i,
  output logic        wr_ready_o,
  input  logic [7:0]  wr_data_i,
  input  logic        rd_valid_i,
  output logic        rd_ready_o,
  output logic        rd_data_valid_o,
  output logic [7:0]  rd_data_o,
  output logic        irq_n_o,
  output logic [7:0]  cfg_o,
  output logic [7:0]  act_time_o,
  output logic [7:0]  debounce_o,
  output logic [7:0]  key_size_o,
  output logic [7:0]  clk_cfg_o,
  output logic [15:0] gpio_pull_o,
  output logic [15:0] gpio_dir_o,
  output logic [15:0] gpio_state_o,
  output logic        key_flush_o,
  output logic        pwm_wr_valid_o,
  output logic [7:0]  pwm_wr_addr_o,
  output logic [15:0] pwm_wr_data_o,
  output logic        pwm_start_valid_o,
  output logic [1:0]  pwm_start_chan_o,
  output logic [5:0]  pwm_start_addr_o,
  output logic        pwm_stop_valid_o,
  output logic [1:0]  pwm_stop_chan_o
);
  logic             wr_fire, rd_fire;
  logic [7:0]       cmd;
  logic [CYC_W-1:0] cyc;
  wr_act_t          act;
  logic [7:0]       status, err, rd_data;
  logic             rd_clr, rd_unk;
  logic [15:0]      gpio [NUM_GPIO_WORDS];

  assign wr_ready_o = !start_i;
  assign rd_ready_o = !start_i && !wr_valid_i;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign rd_fire    = rd_valid_i && rd_ready_o;

  kpc_cmd_seq #(.CYC_W(CYC_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .wr_fire_i(wr_fire), .rd_fire_i(rd_fire), .wr_data_i(wr_data_i),
    .park_i(act.park), .cmd_o(cmd), .cyc_o(cyc)
  );

  kpc_wr_decode #(
    .CYC_W(CYC_W), .PWM_STEP_MAX(PWM_STEP_MAX), .KEY_DIM_MIN(KEY_DIM_MIN),
    .KEY_LO_MAX(KEY_LO_MAX), .KEY_HI_MAX(KEY_HI_MAX)
  ) wdec_i (
    .wr_fire_i(wr_fire), .cmd_i(cmd), .cyc_i(cyc), .data_i(wr_data_i), .act_o(act)
  );

  kpc_rd_decode #(.CYC_W(CYC_W)) rdec_i (
    .rd_fire_i(rd_fire), .cmd_i(cmd), .cyc_i(cyc), .status_i(status),
    .err_i(err), .cfg_i(cfg_o), .size_i(key_size_o), .clk_cfg_i(clk_cfg_o),
    .dir_i(gpio_dir_o), .state_i(gpio_state_o),
    .data_o(rd_data), .clr_status_o(rd_clr), .unk_cmd_o(rd_unk)
  );

  kpc_reg_file regs_i (
    .clk(clk), .rst_n(rst_n), .act_i(act), .data_i(wr_data_i),
    .rd_clr_i(rd_clr), .rd_unk_i(rd_unk),
    .status_o(status), .err_o(err), .cfg_o(cfg_o), .act_time_o(act_time_o),
    .debounce_o(debounce_o), .key_size_o(key_size_o), .clk_cfg_o(clk_cfg_o),
    .gpio_o(gpio), .key_flush_o(key_flush_o),
    .pwm_wr_valid_o(pwm_wr_valid_o), .pwm_wr_addr_o(pwm_wr_addr_o),
    .pwm_wr_data_o(pwm_wr_data_o), .pwm_go_valid_o(pwm_start_valid_o),
    .pwm_go_chan_o(pwm_start_chan_o), .pwm_go_step_o(pwm_start_addr_o),
    .pwm_halt_valid_o(pwm_stop_valid_o), .pwm_halt_chan_o(pwm_stop_chan_o)
  );

  assign gpio_pull_o  = gpio[0];
  assign gpio_dir_o   = gpio[1];
  assign gpio_state_o = gpio[2];

  logic       rdv_q;
  logic [7:0] rdd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= 8'h00;
    end else begin
      rdv_q <= rd_fire;
      if (rd_fire) rdd_q <= rd_data;
    end
  end

  assign rd_data_valid_o = rdv_q;
  assign rd_data_o       = rdd_q;
  assign irq_n_o         = (status == 8'h00);
endmodule

// File: rtl/kpc_cmd_proc_chk.sv
module kpc_cmd_proc_chk #(
  parameter int PWM_STEP_MAX = 59
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid_i,
  input logic       wr_ready_o,
  input logic       rd_valid_i,
  input logic       rd_ready_o,
  input logic       rd_data_valid_o,
  input logic       irq_n_o,
  input logic [7:0] cfg_o,
  input logic       key_flush_o,
  input logic       pwm_wr_valid_o,
  input logic       pwm_start_valid_o,
  input logic [1:0] pwm_start_chan_o,
  input logic [5:0] pwm_start_addr_o,
  input logic       pwm_stop_valid_o
);
  AST_RD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && rd_ready_o) |=> rd_data_valid_o);                       // R13
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_i && rd_ready_o) |=> !rd_data_valid_o);                     // R13
  AST_IRQ_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> ($past(rd_valid_i && rd_ready_o) ||
                        $past(wr_valid_i && wr_ready_o)));                 // R11
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_flush_o |-> $past(wr_valid_i && wr_ready_o));                      // R6
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid_i && wr_ready_o) |-> $stable(cfg_o));                  // R2
  AST_PWM_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwm_wr_valid_o, pwm_start_valid_o, pwm_stop_valid_o}));     // R10
  AST_PWM_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_start_valid_o |-> (pwm_start_chan_o != 2'b00) &&
                          (int'(pwm_start_addr_o) <= PWM_STEP_MAX));       // R10
endmodule

bind kpc_cmd_proc kpc_cmd_proc_chk #(.PWM_STEP_MAX(PWM_STEP_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o),
  .rd_data_valid_o(rd_data_valid_o), .irq_n_o(irq_n_o), .cfg_o(cfg_o),
  .key_flush_o(key_flush_o), .pwm_wr_valid_o(pwm_wr_valid_o),
  .pwm_start_valid_o(pwm_start_valid_o), .pwm_start_chan_o(pwm_start_chan_o),
  .pwm_start_addr_o(pwm_start_addr_o), .pwm_stop_valid_o(pwm_stop_valid_o)
);

// File: tb/kpc_cmd_proc_tb_top.sv
`timescale 1ns/100ps
module kpc_cmd_proc_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start_i, wr_valid_i, rd_valid_i;
  logic [7:0]  wr_data_i;
  logic        wr_ready_o, rd_ready_o, rd_data_valid_o, irq_n_o, key_flush_o;
  logic [7:0]  rd_data_o, cfg_o, act_time_o, debounce_o, key_size_o, clk_cfg_o;
  logic [15:0] gpio_pull_o, gpio_dir_o, gpio_state_o, pwm_wr_data_o;
  logic        pwm_wr_valid_o, pwm_start_valid_o, pwm_stop_valid_o;
  logic [7:0]  pwm_wr_addr_o;
  logic [1:0]  pwm_start_chan_o, pwm_stop_chan_o;
  logic [5:0]  pwm_start_addr_o;

  kpc_cmd_proc dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    wr_valid_i = 1'b1; wr_data_i = b; @(negedge clk); wr_valid_i = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    rd_valid_i = 1'b1; @(negedge clk); rd_valid_i = 1'b0;
    chk("R13 answer valid", rd_data_valid_o, 1'b1);
    b = rd_data_o;
  endtask

  task automatic cmd1(input logic [7:0] c, input logic [7:0] p);
    do_start(); wr_byte(c); wr_byte(p);
  endtask

  task automatic rd_at(input logic [7:0] c, input int idx, output logic [7:0] b);
    do_start(); wr_byte(c); do_start();
    for (int i = 0; i <= idx; i++) rd_byte(b);
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [7:0] b;
    rd_at(8'h82, 0, b);
    chk(req, b, exp);
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk("R1 cfg", cfg_o, 8'h80);
    chk("R1 act", act_time_o, 8'd125);
    chk("R1 deb", debounce_o, 8'd3);
    chk("R1 size", key_size_o, 8'h33);
    chk("R1 clk", clk_cfg_o, 8'h08);
    chk("R1 gpio", {gpio_pull_o, gpio_dir_o, gpio_state_o}, 0);
    chk("R1 irq low", irq_n_o, 1'b0);
    chk_status("R6 status noinit read", 8'h10);
    chk_status("R6 noinit not cleared", 8'h10);
    rd_at(8'h8C, 0, b); chk("R4 error after reset", b, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] b;
    cmd1(8'h81, 8'hAC);
    chk("R6 flush pulse", key_flush_o, 1'b1);
    chk("R6 cfg stored", cfg_o, 8'hAC);
    chk("R11 irq released", irq_n_o, 1'b1);
    @(negedge clk);
    chk("R6 flush one cycle", key_flush_o, 1'b0);
    rd_at(8'h92, 0, b); chk("R8 cfg low nibble", b, 8'h0C);
    chk_status("R6 status cleared by cfg", 8'h00);
  endtask

  task automatic t_id();
    logic [7:0] b;
    do_start(); wr_byte(8'h80); do_start();
    rd_byte(b); chk("R8 id byte0", b, 8'h00);
    rd_byte(b); chk("R8 id byte1", b, 8'h04);
    rd_byte(b); chk("R12 id byte2", b, 8'h00);
  endtask

  task automatic t_park();
    logic [7:0] b;
    do_start(); wr_byte(8'h8B); wr_byte(8'h40);
    chk("R8 act stored", act_time_o, 8'h40);
    chk("R11 irq high no error", irq_n_o, 1'b1);
    wr_byte(8'h11);
    chk("R3 surplus byte irq", irq_n_o, 1'b0);
    chk("R3 act unchanged", act_time_o, 8'h40);
    rd_at(8'h8C, 0, b); chk("R3 error bit0", b, 8'h01);
    chk_status("R3 status bit3", 8'h08);
    chk("R6 read clears irq", irq_n_o, 1'b1);
    chk_status("R6 status now zero", 8'h00);
  endtask

  task automatic t_unknown();
    logic [7:0] b;
    cmd1(8'h8D, 8'h00);
    chk("R4 unknown irq", irq_n_o, 1'b0);
    rd_at(8'h8C, 0, b); chk("R4 error bits", b, 8'h03);
    chk_status("R4 status bit3", 8'h08);
    rd_at(8'h89, 0, b); chk("R4 unknown read data", b, 8'h00);
    chk_status("R4 unknown read status", 8'h08);
  endtask

  task automatic t_args();
    logic [7:0] b;
    cmd1(8'h8F, 8'h00); chk("R7 deb stored", debounce_o, 8'h00);
    chk_status("R7 deb zero bad", 8'h08);
    cmd1(8'h8F, 8'h05); chk_status("R7 deb ok", 8'h00);
    chk("R7 deb 5", debounce_o, 8'h05);
    cmd1(8'h90, 8'h84); chk_status("R7 size 84 ok", 8'h00);
    cmd1(8'h90, 8'h2C); chk_status("R7 size hi 2 bad", 8'h08);
    cmd1(8'h90, 8'h3D); chk_status("R7 size lo 13 bad", 8'h08);
    cmd1(8'h90, 8'h93); chk_status("R7 size hi 9 bad", 8'h08);
    cmd1(8'h90, 8'h3C); chk_status("R7 size 3C ok", 8'h00);
    rd_at(8'h91, 0, b); chk("R7 size readback", b, 8'h3C);
    cmd1(8'h93, 8'h0B); chk_status("R7 clk 11 ok", 8'h00);
    rd_at(8'h94, 0, b); chk("R7 clk readback", b, 8'h0A);
    cmd1(8'h93, 8'h01); chk_status("R7 clk 01 bad", 8'h08);
    cmd1(8'h93, 8'h02); chk_status("R7 clk 10 bad", 8'h08);
    chk("R7 clk stored", clk_cfg_o, 8'h02);
  endtask

  task automatic t_gpio();
    logic [7:0] b;
    do_start(); wr_byte(8'h85); wr_byte(8'h34); wr_byte(8'h12);
    chk("R9 dir", gpio_dir_o, 16'h1234);
    do_start(); wr_byte(8'h87); do_start();
    rd_byte(b); chk("R9 dir lo", b, 8'h34);
    rd_byte(b); chk("R9 dir hi", b, 8'h12);
    rd_byte(b); chk("R12 dir idx2", b, 8'h00);
    do_start(); wr_byte(8'h84); wr_byte(8'hEF); wr_byte(8'hBE);
    chk("R9 pull", gpio_pull_o, 16'hBEEF);
    wr_byte(8'h00);
    chk_status("R3 surplus after gpio", 8'h08);
    chk("R3 pull unchanged", gpio_pull_o, 16'hBEEF);
    do_start(); wr_byte(8'h86); wr_byte(8'hFF); wr_byte(8'h00);
    chk("R9 state", gpio_state_o, 16'h00FF);
    cmd1(8'h86, 8'h0F);
    chk("R9 low byte clears high", gpio_state_o, 16'h000F);
    chk_status("R9 one byte no error", 8'h00);
    rd_at(8'h88, 0, b); chk("R9 state lo", b, 8'h0F);
  endtask

  task automatic t_pwm();
    cmd1(8'h95, 8'h00); chk_status("R10 addr chan0 bad", 8'h08);
    cmd1(8'h95, 8'hF1); chk_status("R10 addr step60 bad", 8'h08);
    do_start(); wr_byte(8'h95); wr_byte(8'h09);
    chk("R10 no strobe yet", pwm_wr_valid_o, 1'b0);
    wr_byte(8'hAB);
    chk("R10 no strobe hi", pwm_wr_valid_o, 1'b0);
    wr_byte(8'hCD);
    chk("R10 wr strobe", pwm_wr_valid_o, 1'b1);
    chk("R10 wr addr", pwm_wr_addr_o, 8'h09);
    chk("R10 wr data", pwm_wr_data_o, 16'hABCD);
    chk_status("R10 wr ok", 8'h00);
    do_start(); wr_byte(8'h95); wr_byte(8'hEF); wr_byte(8'h00); wr_byte(8'h01);
    chk("R10 step59 strobe", pwm_wr_valid_o, 1'b1);
    chk("R10 step59 data", {pwm_wr_addr_o, pwm_wr_data_o}, 24'hEF0001);
    cmd1(8'h96, 8'h0E);
    chk("R10 start strobe", pwm_start_valid_o, 1'b1);
    chk("R10 start fields", {pwm_start_chan_o, pwm_start_addr_o}, {2'd2, 6'd3});
    cmd1(8'h96, 8'hF3);
    chk("R10 bad start no strobe", pwm_start_valid_o, 1'b0);
    chk_status("R10 start step60 bad", 8'h08);
    cmd1(8'h97, 8'h02);
    chk("R10 stop strobe", pwm_stop_valid_o, 1'b1);
    chk("R10 stop chan", pwm_stop_chan_o, 2'd2);
    cmd1(8'h97, 8'h04);
    chk("R10 bad stop no strobe", pwm_stop_valid_o, 1'b0);
    chk_status("R10 stop chan0 bad", 8'h08);
  endtask

  task automatic t_rdzero();
    logic [7:0] b;
    rd_at(8'h83, 0, b); chk("R12 write-only read", b, 8'h00);
    chk_status("R12 no error write-only", 8'h00);
    do_start(); wr_byte(8'h8B); wr_byte(8'h33); do_start();
    rd_byte(b); chk("R12 parked read", b, 8'h00);
    chk_status("R12 no error parked", 8'h00);
  endtask

  task automatic t_hs();
    @(negedge clk);
    chk("R13 no answer idle", rd_data_valid_o, 1'b0);
    start_i = 1'b1; wr_valid_i = 1'b1; wr_data_i = 8'h00; #0.5;
    chk("R13 wr blocked by start", wr_ready_o, 1'b0);
    start_i = 1'b0; #0.5;
    chk("R13 wr ready", wr_ready_o, 1'b1);
    chk("R13 rd blocked by write", rd_ready_o, 1'b0);
    wr_valid_i = 1'b0; #0.5;
    chk("R13 rd ready", rd_ready_o, 1'b1);
  endtask

  task automatic t_rst_cmd();
    cmd1(8'h83, 8'h55);
    chk("R5 bad key cfg kept", cfg_o, 8'hAC);
    chk_status("R5 bad key", 8'h08);
    cmd1(8'h83, 8'hAA);
    chk("R5 cfg", cfg_o, 8'h80);
    chk("R5 act/deb", {act_time_o, debounce_o}, {8'd125, 8'd3});
    chk("R5 size/clk", {key_size_o, clk_cfg_o}, {8'h33, 8'h08});
    chk("R5 irq low", irq_n_o, 1'b0);
    chk_status("R5 status noinit", 8'h10);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; wr_valid_i = 1'b0; rd_valid_i = 1'b0; wr_data_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_id();
    t_park();
    t_unknown();
    t_args();
    t_gpio();
    t_pwm();
    t_rdzero();
    t_hs();
    t_rst_cmd();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule